// File: doc/BRIEF.md
# SHA-1 Message Schedule and Rotate Unit

This block computes the three helper steps that a SHA-1 engine needs besides its compression rounds. It works on 128-bit vectors made of four 32-bit lanes, with lane 0 in bits 31:0. The three steps are the first and second stages of the message-schedule update and a fixed rotate of one 32-bit word. A caller presents an operation code with an accumulator operand `d` and two further operands `n` and `m`, and raises `in_valid`.

On the next clock edge the unit registers the 128-bit result and raises `out_valid`. The schedule stages split the work on the sixteen-word message window across two operations. The scalar rotate produces the value that feeds the next round's `e` word. Instruction decoding and the compression rounds themselves live elsewhere.

Top module: `sha1_sched_unit`

## Requirements
- R1: While `rst` is high at a rising clock edge, `result` becomes all zeros and `out_valid` becomes 0.
- R2: `out_valid` equals the value `in_valid` had at the previous rising edge, so the latency is exactly one cycle.
- R3: When `in_valid` is low at a rising edge, `result` keeps its previous value.
- R4: With `op` = 2'b00 (scalar rotate), `result[31:0]` is `n[31:0]` rotated right by 2 and `result[127:32]` is zero. `d` and `m` have no effect.
- R5: With `op` = 2'b01 (schedule stage 0), `result` = T ^ `d` ^ `m`. Here T[63:0] = `d[127:64]` and T[127:64] = `n[63:0]`.
- R6: With `op` = 2'b10 (schedule stage 1), the unit forms W = `d` ^ (`n` >> 32), a logical 128-bit shift. Result lanes 0, 1 and 2 are the matching W lanes rotated left by 1. `m` has no effect.
- R7: With `op` = 2'b10, result lane 3 (bits 127:96) is W lane 3 rotated left by 1, XORed with W lane 0 rotated left by 2.
- R8: With `op` = 2'b11 (reserved), the registered `result` is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operands and op are valid this cycle |
| op | input | 2 | 00 rotate, 01 stage 0, 10 stage 1, 11 reserved |
| d | input | 128 | Accumulator operand |
| n | input | 128 | Second operand |
| m | input | 128 | Third operand, used by stage 0 only |
| out_valid | output | 1 | Result registered from a valid input |
| result | output | 128 | Registered result |

## Verification
Every result appears on the outputs at the first rising edge after the request is accepted. The bench therefore drives each request on a falling edge and compares `result` and `out_valid` on the following falling edge, one cycle later with no slack. Hold checks drive an idle cycle with changed operands and compare on the next falling edge that `result` is unchanged and `out_valid` is low. The reset check samples on the falling edge after `rst` was seen high.

// File: rtl/sha1_sched_pkg.sv
package sha1_sched_pkg;
   typedef enum logic [1:0] {
      OP_ROTATE = 2'b00,
      OP_STAGE0 = 2'b01,
      OP_STAGE1 = 2'b10,
      OP_RSVD   = 2'b11
   } sched_op_e;
endpackage

// File: rtl/sha1_scalar_rot.sv
module sha1_scalar_rot #(
   parameter int LANE_W = 32,
   parameter int LANES  = 4,
   parameter int ROT_R  = 2,
   localparam int VEC_W = LANE_W * LANES
) (
   input  logic [VEC_W-1:0] src,
   output logic [VEC_W-1:0] dst
);
   logic [LANE_W-1:0] word;

   if (ROT_R <= 0 || ROT_R >= LANE_W) begin : g_bad_rot
      $error("sha1_scalar_rot: ROT_R out of range");
   end

   assign word = src[LANE_W-1:0];

   always_comb begin
      dst = '0;
      dst[LANE_W-1:0] = (word >> ROT_R) | (word << (LANE_W - ROT_R));
   end
endmodule

// File: rtl/sha1_sched_stage0.sv
module sha1_sched_stage0 #(
   parameter int LANE_W = 32,
   parameter int LANES  = 4,
   localparam int VEC_W = LANE_W * LANES,
   localparam int HALF  = VEC_W / 2
) (
   input  logic [VEC_W-1:0] acc,
   input  logic [VEC_W-1:0] opn,
   input  logic [VEC_W-1:0] opm,
   output logic [VEC_W-1:0] dst
);
   logic [VEC_W-1:0] spliced;

   if (LANES % 2 != 0) begin : g_bad_lanes
      $error("sha1_sched_stage0: LANES must be even");
   end

   assign spliced = {opn[HALF-1:0], acc[VEC_W-1:HALF]};
   assign dst     = spliced ^ acc ^ opm;
endmodule

// File: rtl/sha1_sched_stage1.sv
module sha1_sched_stage1 #(
   parameter int LANE_W  = 32,
   parameter int LANES   = 4,
   parameter int ROT_A   = 1,
   parameter int ROT_FIX = 2,
   localparam int VEC_W  = LANE_W * LANES
) (
   input  logic [VEC_W-1:0] acc,
   input  logic [VEC_W-1:0] opn,
   output logic [VEC_W-1:0] dst
);
   logic [VEC_W-1:0]  mixed;
   logic [LANE_W-1:0] fix_word;

   if (ROT_A <= 0 || ROT_A >= LANE_W || ROT_FIX <= 0 || ROT_FIX >= LANE_W) begin : g_bad_rot
      $error("sha1_sched_stage1: rotate amount out of range");
   end

   assign mixed    = acc ^ (opn >> LANE_W);
   assign fix_word = (mixed[LANE_W-1:0] << ROT_FIX) |
                     (mixed[LANE_W-1:0] >> (LANE_W - ROT_FIX));

   for (genvar i = 0; i < LANES; i++) begin : g_lane
      logic [LANE_W-1:0] w;
      logic [LANE_W-1:0] r;
      assign w = mixed[i*LANE_W +: LANE_W];
      assign r = (w << ROT_A) | (w >> (LANE_W - ROT_A));
      if (i == LANES - 1) begin : g_top
         assign dst[i*LANE_W +: LANE_W] = r ^ fix_word;
      end else begin : g_plain
         assign dst[i*LANE_W +: LANE_W] = r;
      end
   end
endmodule

// File: rtl/sha1_sched_unit.sv
module sha1_sched_unit #(
   parameter int LANE_W = 32,
   parameter int LANES  = 4,
   localparam int VEC_W = LANE_W * LANES
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             in_valid,
   input  logic [1:0]       op,
   input  logic [VEC_W-1:0] d,
   input  logic [VEC_W-1:0] n,
   input  logic [VEC_W-1:0] m,
   output logic             out_valid,
   output logic [VEC_W-1:0] result
);
   import sha1_sched_pkg::*;

   logic [VEC_W-1:0] rot_val;
   logic [VEC_W-1:0] s0_val;
   logic [VEC_W-1:0] s1_val;
   logic [VEC_W-1:0] next_val;
   logic [VEC_W-1:0] res_q;
   logic             vld_q;

   if (LANE_W != 32 || LANES != 4) begin : g_bad_shape
      $error("sha1_sched_unit: only 4 lanes of 32 bits are defined");
   end

   sha1_scalar_rot #(.LANE_W(LANE_W), .LANES(LANES), .ROT_R(2)) u_rot (
      .src (n),
      .dst (rot_val)
   );

   sha1_sched_stage0 #(.LANE_W(LANE_W), .LANES(LANES)) u_s0 (
      .acc (d),
      .opn (n),
      .opm (m),
      .dst (s0_val)
   );

   sha1_sched_stage1 #(.LANE_W(LANE_W), .LANES(LANES), .ROT_A(1), .ROT_FIX(2)) u_s1 (
      .acc (d),
      .opn (n),
      .dst (s1_val)
   );

   always_comb begin
      case (sched_op_e'(op))
         OP_ROTATE: next_val = rot_val;
         OP_STAGE0: next_val = s0_val;
         OP_STAGE1: next_val = s1_val;
         default:   next_val = '0;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         res_q <= '0;
         vld_q <= 1'b0;
      end else begin
         vld_q <= in_valid;
         if (in_valid) begin
            res_q <= next_val;
         end
      end
   end

   assign out_valid = vld_q;
   assign result    = res_q;
endmodule

// File: rtl/sha1_sched_chk.sv
module sha1_sched_chk #(
   parameter int VEC_W = 128
) (
   input logic             clk,
   input logic             rst,
   input logic             in_valid,
   input logic [1:0]       op,
   input logic [VEC_W-1:0] n,
   input logic             out_valid,
   input logic [VEC_W-1:0] result
);
   AST_RESET_CLEARS: assert property (@(posedge clk) rst |=> (!out_valid && result == '0)); // R1
   AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst) in_valid |=> out_valid); // R2
   AST_IDLE_NO_VALID: assert property (@(posedge clk) disable iff (rst) !in_valid |=> !out_valid); // R2
   AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst) !in_valid |=> $stable(result)); // R3
   AST_ROT_VALUE: assert property (@(posedge clk) disable iff (rst)
      (in_valid && op == 2'b00) |=>
      (result[31:0] == {$past(n[1:0]), $past(n[31:2])} && result[VEC_W-1:32] == '0)); // R4
   AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (rst)
      (in_valid && op == 2'b11) |=> (result == '0)); // R8
endmodule

bind sha1_sched_unit sha1_sched_chk #(.VEC_W(VEC_W)) u_chk (
   .clk       (clk),
   .rst       (rst),
   .in_valid  (in_valid),
   .op        (op),
   .n         (n),
   .out_valid (out_valid),
   .result    (result)
);

// File: tb/sim_sha1_sched_unit.sv
`timescale 1ns/1ps
module sim_sha1_sched_unit;
   logic         clk = 1'b0;
   logic         rst = 1'b1;
   logic         in_valid = 1'b0;
   logic [1:0]   op = 2'b00;
   logic [127:0] d = '0;
   logic [127:0] n = '0;
   logic [127:0] m = '0;
   logic         out_valid;
   logic [127:0] result;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;
   logic [31:0] seed = 32'h1234_5678;

   always #5 clk = ~clk;

   sha1_sched_unit u0 (
      .clk(clk), .rst(rst), .in_valid(in_valid), .op(op),
      .d(d), .n(n), .m(m), .out_valid(out_valid), .result(result)
   );

   function automatic logic [31:0] rl(input logic [31:0] x, input int k);
      return (x << k) | (x >> (32 - k));
   endfunction

   function automatic logic [127:0] model(input logic [1:0] o, input logic [127:0] a,
                                          input logic [127:0] b, input logic [127:0] c);
      logic [127:0] w, r;
      case (o)
         2'b00: return {96'd0, rl(b[31:0], 30)};
         2'b01: return {b[63:0], a[127:64]} ^ a ^ c;
         2'b10: begin
            w = a ^ {32'd0, b[127:32]};
            for (int i = 0; i < 4; i++) r[i*32 +: 32] = rl(w[i*32 +: 32], 1);
            r[127:96] = r[127:96] ^ rl(w[31:0], 2);
            return r;
         end
         default: return '0;
      endcase
   endfunction

   function automatic logic [31:0] xs(input logic [31:0] s);
      logic [31:0] t;
      t = s ^ (s << 13);
      t = t ^ (t >> 17);
      t = t ^ (t << 5);
      return t;
   endfunction

   task automatic rnd128(output logic [127:0] v);
      for (int i = 0; i < 4; i++) begin
         seed = xs(seed);
         v[i*32 +: 32] = seed;
      end
   endtask

   task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   endtask

   // one request: drive at negedge, compare one cycle later at negedge
   task automatic issue(input string req, input logic [1:0] o,
                        input logic [127:0] a, input logic [127:0] b, input logic [127:0] c);
      op = o; d = a; n = b; m = c; in_valid = 1'b1;
      @(negedge clk);
      check(req, result, model(o, a, b, c));
      check("R2 valid", {127'd0, out_valid}, 128'd1);
   endtask

   initial begin
      logic [127:0] a, b, c, held;
      repeat (2) @(negedge clk);
      check("R1 result", result, '0);
      check("R1 valid", {127'd0, out_valid}, 128'd0);
      rst = 1'b0;

      // sweep all ops over pseudo-random operands
      for (int k = 0; k < 64; k++) begin
         for (int o = 0; o < 4; o++) begin
            rnd128(a); rnd128(b); rnd128(c);
            case (o)
               0: issue("R4 rotate", 2'b00, a, b, c);
               1: issue("R5 stage0", 2'b01, a, b, c);
               2: issue("R6/R7 stage1", 2'b10, a, b, c);
               default: issue("R8 reserved", 2'b11, a, b, c);
            endcase
         end
      end

      // walking ones through n and d for stage 1 (lane-3 fix from lane 0, R7)
      for (int i = 0; i < 128; i++) begin
         issue("R6 walk n", 2'b10, '0, 128'd1 << i, '1);
         issue("R7 walk d", 2'b10, 128'd1 << i, '0, '0);
         issue("R5 walk n", 2'b01, '0, 128'd1 << i, '0);
      end

      // R4: d and m ignored by rotate
      rnd128(b);
      issue("R4 d/m ignored ones", 2'b00, '1, b, '1);
      issue("R4 d/m ignored zeros", 2'b00, '0, b, '0);

      // R3 / R2: idle cycles hold the result, out_valid low
      rnd128(a); rnd128(b); rnd128(c);
      issue("R5 before hold", 2'b01, a, b, c);
      held = result;
      in_valid = 1'b0; op = 2'b10; d = ~a; n = ~b; m = ~c;
      @(negedge clk);
      check("R3 hold", result, held);
      check("R2 idle valid", {127'd0, out_valid}, 128'd0);
      @(negedge clk);
      check("R3 hold 2", result, held);

      // R1 mid-run reset
      issue("R6 before reset", 2'b10, a, b, c);
      rst = 1'b1;
      @(negedge clk);
      check("R1 mid result", result, '0);
      check("R1 mid valid", {127'd0, out_valid}, 128'd0);
      rst = 1'b0; in_valid = 1'b0;
      @(negedge clk);

      done = 1'b1;
      finish_run();
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++;
         failures++;
         $display("FAIL watchdog actual=timeout expected=completion");
         finish_run();
      end
   end
endmodule